// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit expands one multi-register memory transfer into a series of single-word accesses. A request gives a base address, a register-select mask with one bit per register, a stepping mode, a writeback flag and a load/store selector. The sequencer then presents one word address per access on a valid/ready memory port, together with the number of the register that goes with that access. When the list is used up it raises a one-cycle completion pulse and offers the updated base value for the register file.

The registers are always placed in memory in index order, with the lowest-numbered register at the lowest address. The mode sets only the placement of the block relative to the base and the direction in which the base moves. Increment or decrement, each taken before or after the access, covers every stack discipline. Popping from a full-descending stack is increment-after and popping from an empty-descending stack is increment-before. Popping from a full-ascending stack is decrement-after and popping from an empty-ascending stack is decrement-before. Pushes use the opposite mode for each of these stack types.

Top module: `lsm_seq`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `mem_valid`=0, `done`=0, `wb_valid`=0.
- R2: Each register whose mask bit is set is issued exactly once, in strictly ascending register index order, and no other index is issued.
- R3: Successive accesses of one request use addresses that rise by exactly 4.
- R4: With n set mask bits, the first address is base for mode code 0 (increment after), base+4 for code 1 (increment before), base-4n+4 for code 2 (decrement after) and base-4n for code 3 (decrement before). All arithmetic wraps modulo 2^32.
- R5: `wb_value` at completion is base+4n for mode codes 0 and 1 and base-4n for codes 2 and 3. `wb_valid` is high in the completion cycle exactly when the writeback flag was set.
- R6: While `mem_valid`=1 and `mem_ready`=0, `mem_addr`, `mem_idx` and `mem_valid` hold their values into the next cycle.
- R7: `done` goes high for exactly one cycle, in the cycle after the clock edge that accepts the last access.
- R8: An empty mask produces no access. `done` goes high in the cycle after the request is accepted, and `wb_value` equals the base.
- R9: `mem_load` equals the load selector of the request for every access.
- R10: A request is accepted only when `req_ready`=1, which holds only while idle. A request held on the inputs during a transfer has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this edge if valid |
| req_base | input | 32 | Base address |
| req_mask | input | 16 | Register-select mask, bit i selects register i |
| req_mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| req_wb | input | 1 | Write back updated base |
| req_load | input | 1 | 1 load, 0 store |
| mem_valid | output | 1 | Access presented |
| mem_ready | input | 1 | Memory takes the access this edge |
| mem_addr | output | 32 | Word address of the access |
| mem_idx | output | 4 | Register index of the access |
| mem_load | output | 1 | Direction of the access |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Writeback requested, with done |
| wb_value | output | 32 | Updated base value |

## Verification
The hardest case to reach from the ports is the completion timing when the final access is stalled by memory for several cycles, so that the last handshake and the pulse after it are separated from the rest of the run by stall cycles. The stimulus drops `mem_ready` at random on each cycle, using sparse masks, single-bit masks, the full mask and the empty mask. A different request is held on the inputs for the whole of each transfer, which tests that nothing is accepted while the sequencer is busy. Bases near zero and near the top of the address space make the decrement modes wrap.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    MODE_INC_AFTER  = 2'd0,
    MODE_INC_BEFORE = 2'd1,
    MODE_DEC_AFTER  = 2'd2,
    MODE_DEC_BEFORE = 2'd3
  } step_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) count = count + CW'(bits[i]);
  end
endmodule

// File: rtl/lsm_pick_low.sv
module lsm_pick_low #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (bits[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsm_addr_calc.sv
module lsm_addr_calc
  import lsm_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  input  step_mode_e    mode,
  output logic [AW-1:0] start,
  output logic [AW-1:0] final_base
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
  logic [AW-1:0] span;
  assign span = AW'(count) * STEP;

  always_comb begin
    unique case (mode)
      MODE_INC_AFTER:  start = base;
      MODE_INC_BEFORE: start = base + STEP;
      MODE_DEC_AFTER:  start = base - span + STEP;
      default:         start = base - span;
    endcase
    final_base = mode[1] ? (base - span) : (base + span);
  end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  parameter int IW         = $clog2(NREG),
  parameter int CW         = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_base,
  input  logic [NREG-1:0] req_mask,
  input  logic [1:0]      req_mode,
  input  logic            req_wb,
  input  logic            req_load,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [AW-1:0]   mem_addr,
  output logic [IW-1:0]   mem_idx,
  output logic            mem_load,
  output logic            done,
  output logic            wb_valid,
  output logic [AW-1:0]   wb_value
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  seq_state_e      state_q;
  logic [NREG-1:0] pend_q, pend_nx, pick_in;
  logic [AW-1:0]   addr_q, wbval_q;
  logic [IW-1:0]   idx_q, pick_idx;
  logic            pick_any;
  logic            load_q, wb_q, done_q, wbv_q;
  logic [CW-1:0]   req_cnt;
  logic [AW-1:0]   start_addr, final_base;
  logic            accept, hs;

  assign accept = req_valid && (state_q == ST_IDLE);
  assign hs     = mem_ready && (state_q == ST_RUN);

  lsm_popcount #(.W(NREG), .CW(CW)) u_cnt (
    .bits(req_mask), .count(req_cnt)
  );

  lsm_addr_calc #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_calc (
    .base(req_base), .count(req_cnt), .mode(step_mode_e'(req_mode)),
    .start(start_addr), .final_base(final_base)
  );

  always_comb begin
    pend_nx = pend_q;
    pend_nx[idx_q] = 1'b0;
  end

  assign pick_in = (state_q == ST_IDLE) ? req_mask : pend_nx;

  lsm_pick_low #(.W(NREG), .IW(IW)) u_pick (
    .bits(pick_in), .idx(pick_idx), .any(pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
      wbval_q <= '0;
      done_q  <= 1'b0;
      wbv_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      wbv_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            pend_q  <= req_mask;
            addr_q  <= start_addr;
            idx_q   <= pick_idx;
            load_q  <= req_load;
            wb_q    <= req_wb;
            wbval_q <= final_base;
            if (pick_any) begin
              state_q <= ST_RUN;
            end else begin
              state_q <= ST_FIN;
              done_q  <= 1'b1;
              wbv_q   <= req_wb;
            end
          end
        end
        ST_RUN: begin
          if (hs) begin
            pend_q <= pend_nx;
            if (pick_any) begin
              addr_q <= addr_q + STEP;
              idx_q  <= pick_idx;
            end else begin
              state_q <= ST_FIN;
              done_q  <= 1'b1;
              wbv_q   <= wb_q;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_valid = (state_q == ST_RUN);
  assign mem_addr  = addr_q;
  assign mem_idx   = idx_q;
  assign mem_load  = load_q;
  assign done      = done_q;
  assign wb_valid  = wbv_q;
  assign wb_value  = wbval_q;
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int AW = 32,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [IW-1:0] mem_idx,
  input logic          done,
  input logic          wb_valid
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_idx)));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready) |=> (!mem_valid || mem_addr == $past(mem_addr) + AW'(4)));

  assert_order_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready) |=> (!mem_valid || mem_idx > $past(mem_idx)));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && mem_valid));

  assert_wb_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> done);
endmodule

bind lsm_seq lsm_seq_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_idx(mem_idx),
  .done(done), .wb_valid(wb_valid)
);

// File: tb/tb_lsm_seq.sv
module tb_lsm_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_base = '0;
  logic [15:0] req_mask = '0;
  logic [1:0]  req_mode = '0;
  logic        req_wb = 1'b0, req_load = 1'b0;
  logic        mem_valid, mem_ready = 1'b0, mem_load;
  logic [31:0] mem_addr, wb_value;
  logic [3:0]  mem_idx;
  logic        done, wb_valid;

  int total = 0, bad = 0;
  int cycles = 0;
  bit timed_out = 1'b0;

  always #4 clk = ~clk;

  lsm_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_mask(req_mask), .req_mode(req_mode),
    .req_wb(req_wb), .req_load(req_load), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_idx(mem_idx),
    .mem_load(mem_load), .done(done), .wb_valid(wb_valid), .wb_value(wb_value)
  );

  function automatic int cnt_bits(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [31:0] exp_start(input logic [31:0] b, input logic [15:0] m,
                                            input logic [1:0] md);
    logic [31:0] n4 = 32'(cnt_bits(m) * 4);
    case (md)
      2'd0: return b;
      2'd1: return b + 32'd4;
      2'd2: return b - n4 + 32'd4;
      default: return b - n4;
    endcase
  endfunction

  function automatic logic [31:0] exp_wb(input logic [31:0] b, input logic [15:0] m,
                                         input logic [1:0] md);
    logic [31:0] n4 = 32'(cnt_bits(m) * 4);
    return md[1] ? b - n4 : b + n4;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                         input bit wb, input bit ld, input int stall_pct);
    int n = cnt_bits(m);
    int k = 0;
    int nxt = 0;
    int guard = 0;
    bit prev_hs_last;
    logic [31:0] a0 = exp_start(b, m, md);
    @(negedge clk);
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_base = b; req_mask = m; req_mode = md;
    req_wb = wb; req_load = ld;
    prev_hs_last = (n == 0);
    @(negedge clk);
    // R10: hold a different request on the inputs while busy
    req_base = ~b; req_mask = ~m; req_mode = ~md; req_wb = ~wb; req_load = ~ld;
    guard = 0;
    forever begin
      if (done) begin
        check(k == n, "R7 done after all accesses", 32'(k), 32'(n));
        check(prev_hs_last, "R7 done one cycle after last accept", 32'(prev_hs_last), 32'd1);
        check(wb_value == exp_wb(b, m, md), n == 0 ? "R8 empty wb base" : "R5 wb value",
              wb_value, exp_wb(b, m, md));
        check(wb_valid == wb, "R5 wb_valid", 32'(wb_valid), 32'(wb));
        check(!mem_valid, "R8 no access at done", 32'(mem_valid), 32'd0);
        req_valid = 1'b0;
        mem_ready = 1'b0;
        @(negedge clk);
        check(!done, "R7 done one cycle", 32'(done), 32'd0);
        check(req_ready, "R10 idle after done", 32'(req_ready), 32'd1);
        return;
      end
      prev_hs_last = 1'b0;
      if (mem_valid) begin
        while (nxt < 16 && !m[nxt]) nxt++;
        check(k < n, "R2 no extra access", 32'(k), 32'(n));
        check(mem_idx == 4'(nxt), "R2 index order", 32'(mem_idx), 32'(nxt));
        check(mem_addr == a0 + 32'(4 * k), k == 0 ? "R4 start address" : "R3 step",
              mem_addr, a0 + 32'(4 * k));
        check(mem_load == ld, "R9 direction", 32'(mem_load), 32'(ld));
        check(!req_ready, "R10 busy", 32'(req_ready), 32'd0);
        mem_ready = ($urandom_range(99) >= stall_pct);
        if (mem_ready) begin
          k++; nxt++;
          prev_hs_last = (k == n);
        end
      end else begin
        check(0, "R8 expected access or done", 32'(mem_valid), 32'd1);
        mem_ready = 1'b0;
      end
      @(negedge clk);
      guard++;
      if (guard > 400) begin
        check(0, "watchdog run", 32'(guard), 32'd400);
        req_valid = 1'b0;
        return;
      end
    end
  endtask

  initial begin
    process p;
    p = process::self();
    p.srandom(32'd20240);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !mem_valid && !done && !wb_valid, "R1 reset state",
          {28'd0, req_ready, mem_valid, done, wb_valid}, 32'h8);
    // directed corners
    for (int md = 0; md < 4; md++) run_req(32'h0000_1000, 16'h0000, 2'(md), 1'b1, 1'b0, 0);
    for (int md = 0; md < 4; md++) run_req(32'h0000_0008, 16'hFFFF, 2'(md), 1'b1, 1'b1, 30);
    run_req(32'hFFFF_FFF0, 16'h8000, 2'd1, 1'b0, 1'b0, 60);
    run_req(32'h0000_0000, 16'h0001, 2'd3, 1'b1, 1'b1, 80);
    run_req(32'h0000_4000, 16'h8001, 2'd2, 1'b1, 1'b0, 90);
    // random
    for (int t = 0; t < 120; t++) begin
      logic [15:0] m = 16'($urandom);
      if (t % 7 == 0) m = m & 16'($urandom);
      run_req($urandom, m, 2'($urandom_range(3)), 1'($urandom_range(1)),
              1'($urandom_range(1)), $urandom_range(70));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !timed_out) begin
      timed_out = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule